// File: doc/BRIEF.md
# SD Host Line-Busy Status Tracker

This block follows the occupancy of the command line and the data lines of an SD host controller. Strobes from the command and data engines drive two state machines. They produce the command-inhibit, data-inhibit, data-line-active and read-active status bits, and one-cycle command-complete and transfer-complete interrupt pulses. The block also decides whether a newly written command is accepted. It drives a read-wait request when a read transfer is paused at a block gap.

The command machine has three states. C_IDLE goes to C_WAIT on an accepted command. C_WAIT goes back to C_IDLE when the response arrives, or to C_STUCK on a conflict or not-issued error. C_STUCK is left only by reset.

The data machine has eight states. D_IDLE goes to D_WR_CMD or D_RD_XFER on an accepted data or busy command. D_WR_CMD goes to D_WR_XFER, or to D_WR_LAST for a busy-response command, on the command end bit. D_WR_XFER goes to D_WR_LAST on the last block end bit, or to D_WR_GAP on a stop request at a gap. D_WR_LAST goes to D_IDLE on busy release. D_WR_GAP goes to D_WR_PAUSE on busy release. D_WR_PAUSE goes to D_WR_XFER on continue. D_RD_XFER goes to D_IDLE on the last block end bit, or to D_RD_WAIT on a stop request at a gap, or at once while the buffer is full. D_RD_WAIT goes to D_RD_XFER on continue.

Busy release is judged by a counter of consecutive high DAT0 samples taken on SD clock enables.

Top module: `sd_line_busy_tracker`

## Requirements
- R1: `cmd_accept` is high only while `cmd_wr` is high and `cmd_inhibit` is 0. An accepted command raises `cmd_inhibit` on the next clock.
- R2: `resp_rcvd` while waiting clears `cmd_inhibit` on the next clock. `cmd_complete` is high for exactly that one cycle.
- R3: `cmd_conflict_err` or `cmd_not_issued_err` while waiting keeps `cmd_inhibit` at 1 until reset. `cmd_complete` is not raised, even on a later `resp_rcvd`.
- R4: `dat_inhibit` equals `dat_line_active` OR `read_xfer_active`. Each 1-to-0 change of `dat_inhibit` gives a one-cycle `xfer_complete` in the cycle it falls.
- R5: A command with `cmd_has_data` or `cmd_busy_rsp` set is refused while the data machine is out of D_IDLE, paused states included. A command with both flags clear is accepted whenever `cmd_inhibit` is 0.
- R6: For an accepted write command, `dat_line_active` rises on the clock after `cmd_end_bit`. For a busy-response command, the same edge goes straight to the busy-release wait.
- R7: After the last write block, `dat_line_active` falls one clock after the edge that takes the RELEASE_CLKS-th consecutive high DAT0 sample. A sample is taken only when `sd_clk_en` is high. A low sample restarts the count.
- R8: During a write, `stop_gap_req` with `blk_gap` keeps `dat_line_active` high until busy release, then drops it. A following `continue_req` raises it again on the next clock.
- R9: An accepted read command raises `read_xfer_active` on the next clock. `last_blk_end` clears it on the next clock.
- R10: During a read, `stop_gap_req` with `blk_gap`, or with `buf_full` already high, clears `read_xfer_active` and holds `read_wait` high until `continue_req`. After `continue_req`, the read resumes with `read_wait` following `buf_full`.
- R11: While a read is running, `read_wait` equals `buf_full`. Outside reads and read pauses, `read_wait` is 0.
- R12: After synchronous reset, every status and pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_clk_en | input | 1 | One-cycle enable marking an SD clock sample point |
| cmd_wr | input | 1 | Command register written |
| cmd_has_data | input | 1 | Written command moves data blocks |
| cmd_busy_rsp | input | 1 | Written command has a busy-signalling response |
| cmd_is_read | input | 1 | Data direction is card to host |
| cmd_conflict_err | input | 1 | Command conflict detected |
| cmd_not_issued_err | input | 1 | Command not issued because of an auto-stop error |
| resp_rcvd | input | 1 | Command response received |
| cmd_end_bit | input | 1 | End bit of the command sent |
| last_blk_end | input | 1 | End bit of the last data block |
| blk_gap | input | 1 | Data engine is at a block gap |
| dat0 | input | 1 | DAT0 level (low = card busy) |
| stop_gap_req | input | 1 | Stop-at-block-gap request level |
| continue_req | input | 1 | Continue request strobe |
| buf_full | input | 1 | Read buffer cannot take more data |
| cmd_accept | output | 1 | Written command is accepted this cycle |
| cmd_inhibit | output | 1 | Command line busy |
| dat_inhibit | output | 1 | Data lines busy |
| dat_line_active | output | 1 | Write or busy phase holds DAT |
| read_xfer_active | output | 1 | Read transfer running |
| read_wait | output | 1 | Read-wait request to the card |
| cmd_complete | output | 1 | Command-complete interrupt pulse |
| xfer_complete | output | 1 | Transfer-complete interrupt pulse |

## Verification
The bench builds the block with RELEASE_CLKS = 8. It sweeps a single low DAT0 sample through every position of the release window, and one position past it. Each sweep runs with an enable on every clock and with an enable on every second clock, so the exact falling cycle of R7 is checked against a run count kept in the bench. Both error inputs are exercised for R3. Every pause path is exercised: write at a gap, read at a gap, and read with a full buffer.

// File: rtl/sdlb_pkg.sv
package sdlb_pkg;

    typedef enum logic [1:0] {
        C_IDLE,
        C_WAIT,
        C_STUCK
    } cmd_st_t;

    typedef enum logic [2:0] {
        D_IDLE,
        D_WR_CMD,
        D_WR_XFER,
        D_WR_LAST,
        D_WR_GAP,
        D_WR_PAUSE,
        D_RD_XFER,
        D_RD_WAIT
    } dat_st_t;

    function automatic logic holds_dat(dat_st_t s);
        return (s == D_WR_XFER) || (s == D_WR_LAST) || (s == D_WR_GAP);
    endfunction

    function automatic logic reading(dat_st_t s);
        return s == D_RD_XFER;
    endfunction

endpackage

// File: rtl/sdlb_cmd_fsm.sv
module sdlb_cmd_fsm
    import sdlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic fail,
    input  logic resp,
    output logic inhibit,
    output logic complete
);

    cmd_st_t st, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= C_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            C_IDLE:  if (issue) nxt = C_WAIT;
            C_WAIT:  if (fail) nxt = C_STUCK;
                     else if (resp) nxt = C_IDLE;
            C_STUCK: nxt = C_STUCK;
            default: nxt = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) complete <= 1'b0;
        else     complete <= (st != C_IDLE) && (nxt == C_IDLE);
    end

    assign inhibit = (st != C_IDLE);

    // R3
    stuck_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == C_STUCK) |=> (st == C_STUCK) && !complete);

    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        complete |-> !inhibit && $past(inhibit));

    // R2
    cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
        complete |=> !complete);

endmodule

// File: rtl/sdlb_release_cnt.sv
module sdlb_release_cnt #(
    parameter int RELEASE_CLKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic sample_en,
    input  logic dat0,
    output logic released
);

    localparam int CW = $clog2(RELEASE_CLKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RELEASE_CLKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            cnt <= '0;
        end else if (sample_en) begin
            if (!dat0)             cnt <= '0;
            else if (cnt != LIMIT) cnt <= cnt + 1'b1;
        end
    end

    assign released = (cnt == LIMIT);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    // R7
    low_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && sample_en && !dat0) |=> (cnt == '0));

endmodule

// File: rtl/sdlb_dat_fsm.sv
module sdlb_dat_fsm
    import sdlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_read,
    input  logic start_busy_only,
    input  logic cmd_end_bit,
    input  logic last_blk_end,
    input  logic blk_gap,
    input  logic stop_req,
    input  logic cont_req,
    input  logic buf_full,
    input  logic released,
    output logic line_active,
    output logic rd_active,
    output logic read_wait,
    output logic xfer_complete,
    output logic engaged,
    output logic arm_release
);

    dat_st_t st, nxt;
    logic    busy_only;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= D_IDLE;
            busy_only <= 1'b0;
        end else begin
            st <= nxt;
            if (st == D_IDLE && start) busy_only <= start_busy_only;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            D_IDLE:     if (start) nxt = start_read ? D_RD_XFER : D_WR_CMD;
            D_WR_CMD:   if (cmd_end_bit) nxt = busy_only ? D_WR_LAST : D_WR_XFER;
            D_WR_XFER:  if (last_blk_end) nxt = D_WR_LAST;
                        else if (stop_req && blk_gap) nxt = D_WR_GAP;
            D_WR_LAST:  if (released) nxt = D_IDLE;
            D_WR_GAP:   if (released) nxt = D_WR_PAUSE;
            D_WR_PAUSE: if (cont_req) nxt = D_WR_XFER;
            D_RD_XFER:  if (last_blk_end) nxt = D_IDLE;
                        else if (stop_req && (blk_gap || buf_full)) nxt = D_RD_WAIT;
            D_RD_WAIT:  if (cont_req) nxt = D_RD_XFER;
            default:    nxt = D_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) xfer_complete <= 1'b0;
        else     xfer_complete <= (holds_dat(st) || reading(st)) &&
                                  !(holds_dat(nxt) || reading(nxt));
    end

    assign line_active = holds_dat(st);
    assign rd_active   = reading(st);
    assign read_wait   = (st == D_RD_WAIT) || (reading(st) && buf_full);
    assign engaged     = (st != D_IDLE);
    assign arm_release = (st == D_WR_LAST) || (st == D_WR_GAP);

    // R4
    xfer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_complete |-> !(line_active || rd_active) && $past(line_active || rd_active));

    // R10
    rd_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == D_RD_WAIT) |-> read_wait && !rd_active);

    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == D_WR_GAP && !released) |=> line_active);

endmodule

// File: rtl/sd_line_busy_tracker.sv
module sd_line_busy_tracker #(
    parameter int RELEASE_CLKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sd_clk_en,
    input  logic cmd_wr,
    input  logic cmd_has_data,
    input  logic cmd_busy_rsp,
    input  logic cmd_is_read,
    input  logic cmd_conflict_err,
    input  logic cmd_not_issued_err,
    input  logic resp_rcvd,
    input  logic cmd_end_bit,
    input  logic last_blk_end,
    input  logic blk_gap,
    input  logic dat0,
    input  logic stop_gap_req,
    input  logic continue_req,
    input  logic buf_full,
    output logic cmd_accept,
    output logic cmd_inhibit,
    output logic dat_inhibit,
    output logic dat_line_active,
    output logic read_xfer_active,
    output logic read_wait,
    output logic cmd_complete,
    output logic xfer_complete
);

    logic need_dat, dat_engaged, arm_release, released;

    assign need_dat   = cmd_has_data || cmd_busy_rsp;
    assign cmd_accept = cmd_wr && !cmd_inhibit && !(need_dat && dat_engaged);

    sdlb_cmd_fsm u_cmd (
        .clk      (clk),
        .rst      (rst),
        .issue    (cmd_accept),
        .fail     (cmd_conflict_err || cmd_not_issued_err),
        .resp     (resp_rcvd),
        .inhibit  (cmd_inhibit),
        .complete (cmd_complete)
    );

    sdlb_dat_fsm u_dat (
        .clk             (clk),
        .rst             (rst),
        .start           (cmd_accept && need_dat),
        .start_read      (cmd_is_read && cmd_has_data),
        .start_busy_only (!cmd_has_data),
        .cmd_end_bit     (cmd_end_bit),
        .last_blk_end    (last_blk_end),
        .blk_gap         (blk_gap),
        .stop_req        (stop_gap_req),
        .cont_req        (continue_req),
        .buf_full        (buf_full),
        .released        (released),
        .line_active     (dat_line_active),
        .rd_active       (read_xfer_active),
        .read_wait       (read_wait),
        .xfer_complete   (xfer_complete),
        .engaged         (dat_engaged),
        .arm_release     (arm_release)
    );

    sdlb_release_cnt #(.RELEASE_CLKS(RELEASE_CLKS)) u_rel (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm_release),
        .sample_en (sd_clk_en),
        .dat0      (dat0),
        .released  (released)
    );

    assign dat_inhibit = dat_line_active || read_xfer_active;

    // R1
    issue_sets_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |=> cmd_inhibit);

    // R5
    dat_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && need_dat && dat_inhibit) |-> !cmd_accept);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !cmd_inhibit && !dat_inhibit && !cmd_complete && !xfer_complete);

endmodule

// File: tb/sd_line_busy_tracker_tb.sv
module sd_line_busy_tracker_tb;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sd_clk_en = 0, cmd_wr = 0, cmd_has_data = 0, cmd_busy_rsp = 0, cmd_is_read = 0;
    logic cmd_conflict_err = 0, cmd_not_issued_err = 0, resp_rcvd = 0, cmd_end_bit = 0;
    logic last_blk_end = 0, blk_gap = 0, dat0 = 1, stop_gap_req = 0, continue_req = 0, buf_full = 0;
    logic cmd_accept, cmd_inhibit, dat_inhibit, dat_line_active, read_xfer_active;
    logic read_wait, cmd_complete, xfer_complete;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    sd_line_busy_tracker #(.RELEASE_CLKS(N)) u_dut (.*);

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic issue(input logic hd, input logic br, input logic rd);
        cmd_wr = 1; cmd_has_data = hd; cmd_busy_rsp = br; cmd_is_read = rd;
        #1 chk(cmd_accept, 1'b1, "R1", "accept when idle");
        step();
        cmd_wr = 0; cmd_has_data = 0; cmd_busy_rsp = 0; cmd_is_read = 0;
    endtask

    task automatic respond();
        resp_rcvd = 1; step(); resp_rcvd = 0;
        chk(cmd_inhibit, 1'b0, "R2", "inhibit after response");
        chk(cmd_complete, 1'b1, "R2", "complete pulse");
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        // R12
        chk(cmd_inhibit, 0, "R12", "cmd_inhibit");
        chk(dat_inhibit, 0, "R12", "dat_inhibit");
        chk(read_wait, 0, "R12", "read_wait");
        chk(cmd_complete | xfer_complete, 0, "R12", "pulses");

        // R1, R2: command-line only
        issue(0, 0, 0);
        chk(cmd_inhibit, 1, "R1", "inhibit set");
        cmd_wr = 1; #1 chk(cmd_accept, 0, "R1", "refuse while inhibited");
        cmd_wr = 0;
        step();
        respond();
        step();
        chk(cmd_complete, 0, "R2", "pulse one cycle");

        // R3: both error kinds
        for (int e = 0; e < 2; e++) begin
            do_reset();
            issue(0, 0, 0);
            cmd_conflict_err = (e == 0); cmd_not_issued_err = (e == 1); resp_rcvd = 1;
            step();
            cmd_conflict_err = 0; cmd_not_issued_err = 0;
            chk(cmd_inhibit, 1, "R3", "held after error");
            chk(cmd_complete, 0, "R3", "no complete");
            step();
            resp_rcvd = 0;
            chk(cmd_inhibit, 1, "R3", "held after late response");
            chk(cmd_complete, 0, "R3", "still no complete");
        end

        // R6, R7, R4, R5: write with release sweep
        for (int div = 1; div <= 2; div++) begin
            for (int g = 0; g <= N; g++) begin
                int run = 0, samp = 0;
                bit pend = 0, done = 0;
                do_reset();
                issue(1, 0, 0);
                respond();
                cmd_wr = 1; cmd_has_data = 1;
                #1 chk(cmd_accept, 0, "R5", "data cmd refused while armed");
                cmd_has_data = 0;
                #1 chk(cmd_accept, 1, "R5", "cmd-only accepted");
                cmd_wr = 0;
                cmd_end_bit = 1; step(); cmd_end_bit = 0;
                chk(dat_line_active, 1, "R6", "active after end bit");
                chk(dat_inhibit, 1, "R4", "inhibit follows active");
                dat0 = 0; step(); step();
                last_blk_end = 1; step(); last_blk_end = 0;
                chk(dat_line_active, 1, "R7", "still active after last block");
                for (int c = 0; c < 60 && !done; c++) begin
                    bit en, lo;
                    en = (c % div) == 0;
                    lo = en && (samp == g);
                    sd_clk_en = en; dat0 = !lo;
                    step();
                    if (en) begin run = lo ? 0 : run + 1; samp++; end
                    if (pend) begin
                        chk(dat_line_active, 0, "R7", "released");
                        chk(xfer_complete, 1, "R4", "transfer complete pulse");
                        done = 1;
                    end else begin
                        chk(dat_line_active, 1, "R7", "busy window");
                        if (run == N) pend = 1;
                    end
                end
                chk(done, 1, "R7", "release reached");
                sd_clk_en = 0; dat0 = 1;
                step();
                chk(xfer_complete, 0, "R4", "pulse one cycle");
            end
        end

        // R6: busy-response command
        do_reset();
        issue(0, 1, 0);
        respond();
        cmd_end_bit = 1; step(); cmd_end_bit = 0;
        chk(dat_line_active, 1, "R6", "busy wait active");
        sd_clk_en = 1; dat0 = 1;
        for (int c = 0; c < N; c++) step();
        chk(dat_line_active, 1, "R6", "busy before window ends");
        step();
        chk(dat_line_active, 0, "R6", "busy released");
        sd_clk_en = 0;

        // R8: write stop at gap
        do_reset();
        issue(1, 0, 0);
        respond();
        cmd_end_bit = 1; step(); cmd_end_bit = 0;
        stop_gap_req = 1; blk_gap = 1; step(); blk_gap = 0;
        chk(dat_line_active, 1, "R8", "active while card busy at gap");
        sd_clk_en = 1; dat0 = 0; step(); step();
        chk(dat_line_active, 1, "R8", "held while busy low");
        dat0 = 1;
        for (int c = 0; c < N; c++) step();
        step();
        chk(dat_line_active, 0, "R8", "paused after release");
        chk(xfer_complete, 1, "R8", "complete on pause");
        sd_clk_en = 0; stop_gap_req = 0;
        cmd_wr = 1; cmd_has_data = 1;
        #1 chk(cmd_accept, 0, "R5", "refused while paused");
        cmd_wr = 0; cmd_has_data = 0;
        continue_req = 1; step(); continue_req = 0;
        chk(dat_line_active, 1, "R8", "resumed");

        // R9, R10, R11: read
        do_reset();
        issue(1, 0, 1);
        chk(read_xfer_active, 1, "R9", "read active");
        chk(dat_line_active, 0, "R9", "no line active on read");
        chk(dat_inhibit, 1, "R4", "inhibit on read");
        respond();
        buf_full = 1; #1 chk(read_wait, 1, "R11", "wait follows full");
        buf_full = 0; #1 chk(read_wait, 0, "R11", "wait follows not full");
        stop_gap_req = 1; step();
        chk(read_xfer_active, 1, "R10", "runs until gap");
        chk(read_wait, 0, "R10", "no wait before gap");
        blk_gap = 1; step(); blk_gap = 0;
        chk(read_xfer_active, 0, "R10", "stopped at gap");
        chk(read_wait, 1, "R10", "wait at gap");
        chk(xfer_complete, 1, "R4", "complete on read stop");
        stop_gap_req = 0; step();
        chk(read_wait, 1, "R10", "wait held");
        continue_req = 1; step(); continue_req = 0;
        chk(read_xfer_active, 1, "R10", "read resumed");
        chk(read_wait, 0, "R10", "wait dropped");
        buf_full = 1; stop_gap_req = 1; step();
        chk(read_xfer_active, 0, "R10", "stopped at current gap when full");
        chk(read_wait, 1, "R10", "wait kept when full");
        buf_full = 0; stop_gap_req = 0;
        continue_req = 1; step(); continue_req = 0;
        last_blk_end = 1; step(); last_blk_end = 0;
        chk(read_xfer_active, 0, "R9", "cleared on last block");
        chk(xfer_complete, 1, "R9", "complete on last block");
        chk(read_wait, 0, "R11", "no wait when idle");

        finish_run();
    end

endmodule